// File: doc/BRIEF.md
# Decimating Sampler with Gated Clock Export

This block sits in the full-rate sample clock domain, just after the converters. A new converter word arrives on every clock. Software picks an integer decimation factor n. The block keeps one word out of every n and flags each kept word with a single-cycle strobe. The converter clock itself is never slowed. The lower effective rate comes only from dropping words.

Next to the data, the block drives an exported sample clock that follows the effective rate. With n equal to one, the exported clock is a straight copy of the full-rate clock and runs all the time. With n above one, it is a divided clock. That divided clock starts in step with the first kept word, runs only while an acquisition is open, and is parked low as soon as the acquisition closes.

An acquisition opens on a start request and closes on a stop request. The factor and the clock mode are frozen for the whole acquisition.

Top module: `decim_sampler`

## Requirements
- R1: The factor input `div_m1` encodes n = `div_m1` + 1, so 0 through 2^FACT_W-1 give n from 1 to 65536 by default. During an acquisition, kept words are exactly n cycles apart.
- R2: A start request seen while idle, with stop low, raises `acq_active` from the next cycle. The word on `adc_data` during that first active cycle is presented on `out_data` with `out_valid` high one cycle later.
- R3: `out_valid` is a one-cycle strobe per kept word, and `out_data` carries that word. Nothing is kept while `acq_active` is low.
- R4: When the factor frozen for the current or last acquisition is n = 1, `clk_out` equals `clk` in both phases, whether active or idle.
- R5: When n > 1, `clk_out` goes high in the same cycle as each `out_valid` strobe. It stays high for max(1, floor(n/2)) cycles and is low for the remainder of the n-cycle period.
- R6: When n > 1, `clk_out` is low whenever no acquisition is active, including during and straight after reset.
- R7: A stop request during an acquisition drops `acq_active` in the next cycle, even partway through a divided period. In that same cycle `clk_out` is low (n > 1), and no further strobe follows.
- R8: `div_m1` is captured when the acquisition opens. Changes to it while `acq_active` is high have no effect on strobe spacing or clock shape.
- R9: The choice between copy mode (`div_m1` = 0) and divided mode is updated only while idle. A change of `div_m1` to or from 0 during an acquisition does not switch the `clk_out` mode.
- R10: A start request during an acquisition is ignored and does not restart the count. A stop request while idle is ignored. Start and stop together while idle leave the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_start | input | 1 | Request to open an acquisition |
| acq_stop | input | 1 | Request to close the acquisition |
| div_m1 | input | FACT_W | Decimation factor minus one |
| adc_data | input | DATA_W | Converter word, new every cycle |
| out_data | output | DATA_W | Last kept word |
| out_valid | output | 1 | One-cycle strobe per kept word |
| acq_active | output | 1 | High while an acquisition is open |
| clk_out | output | 1 | Exported sample clock |

## Verification
The bench targets the largest factor of 65536. There, a counter that wraps one step early or late, or a half-period computed in too few bits, shows up as a strobe at the wrong spot or a clock high for the wrong length. It stops acquisitions in the middle of the high phase of the divided clock: a design that lets the period finish leaves `clk_out` high, or emits one more strobe, after `acq_active` falls. It changes the factor to zero and fires a second start during acquisitions: a design that reads the live factor, switches mode, or restarts the count produces a different strobe spacing or a runt clock. It also checks the copy mode in both clock phases while active and while idle.

// File: rtl/decim_pkg.sv
package decim_pkg;

    typedef enum logic {
        MODE_DIV  = 1'b0,
        MODE_PASS = 1'b1
    } clk_mode_e;

    typedef enum logic {
        ACQ_IDLE = 1'b0,
        ACQ_RUN  = 1'b1
    } acq_state_e;

endpackage

// File: rtl/decim_ctrl.sv
module decim_ctrl
    import decim_pkg::*;
#(
    parameter int FACT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [FACT_W-1:0] div_m1_i,
    output logic              run_o,
    output logic              halt_o,
    output logic [FACT_W-1:0] n_m1_o,
    output clk_mode_e         mode_o
);

    typedef struct packed {
        acq_state_e        state;
        logic [FACT_W-1:0] n_m1;
        clk_mode_e         mode;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  idle;
    logic  halt;

    always_comb begin
        st_d = st_q;
        idle = (st_q.state == ACQ_IDLE);
        halt = !idle && stop_i;
        if (idle) begin
            // Factor and mode track the input only while idle; frozen once running.
            st_d.n_m1 = div_m1_i;
            st_d.mode = (div_m1_i == '0) ? MODE_PASS : MODE_DIV;
            if (start_i && !stop_i) begin
                st_d.state = ACQ_RUN;
            end
        end else if (halt) begin
            st_d.state = ACQ_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state <= ACQ_IDLE;
            st_q.n_m1  <= '0;
            st_q.mode  <= MODE_DIV;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o  = (st_q.state == ACQ_RUN);
    assign halt_o = halt;
    assign n_m1_o = st_q.n_m1;
    assign mode_o = st_q.mode;

endmodule

// File: rtl/decim_keep.sv
module decim_keep #(
    parameter int DATA_W = 14,
    parameter int FACT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              halt_i,
    input  logic [FACT_W-1:0] n_m1_i,
    input  logic [DATA_W-1:0] adc_i,
    output logic [FACT_W-1:0] cnt_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);

    typedef struct packed {
        logic [FACT_W-1:0] cnt;
        logic [DATA_W-1:0] data;
        logic              valid;
    } keep_t;

    keep_t st_d, st_q;
    logic  keep;

    always_comb begin
        st_d       = st_q;
        keep       = run_i && !halt_i && (st_q.cnt == '0);
        st_d.valid = keep;
        if (keep) begin
            st_d.data = adc_i;
        end
        if (!run_i || halt_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == n_m1_i) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.data  <= '0;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/decim_clkexp.sv
module decim_clkexp
    import decim_pkg::*;
#(
    parameter int FACT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              halt_i,
    input  logic [FACT_W-1:0] cnt_i,
    input  logic [FACT_W-1:0] n_m1_i,
    input  clk_mode_e         mode_i,
    output logic              div_clk_o,
    output logic              clk_out_o
);

    localparam int HW = FACT_W + 1;

    typedef struct packed {
        logic div;
    } clk_t;

    clk_t           st_d, st_q;
    logic [HW-1:0]  half;

    always_comb begin
        st_d = st_q;
        // floor(n/2), at least one; one extra bit so n = 2^FACT_W fits.
        half = ({1'b0, n_m1_i} + HW'(1)) >> 1;
        if (half == '0) begin
            half = HW'(1);
        end
        st_d.div = run_i && !halt_i && ({1'b0, cnt_i} < half);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.div <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_clk_o = st_q.div;

    always_comb begin
        if (mode_i == MODE_PASS) begin
            clk_out_o = clk;
        end else begin
            clk_out_o = st_q.div;
        end
    end

endmodule

// File: rtl/decim_sampler.sv
module decim_sampler
    import decim_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int FACT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_start,
    input  logic              acq_stop,
    input  logic [FACT_W-1:0] div_m1,
    input  logic [DATA_W-1:0] adc_data,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              acq_active,
    output logic              clk_out
);

    logic              run;
    logic              halt;
    logic [FACT_W-1:0] n_m1;
    clk_mode_e         mode;
    logic [FACT_W-1:0] cnt;
    logic              div_clk;

    decim_ctrl #(.FACT_W(FACT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (acq_start),
        .stop_i   (acq_stop),
        .div_m1_i (div_m1),
        .run_o    (run),
        .halt_o   (halt),
        .n_m1_o   (n_m1),
        .mode_o   (mode)
    );

    decim_keep #(.DATA_W(DATA_W), .FACT_W(FACT_W)) u_keep (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .halt_i  (halt),
        .n_m1_i  (n_m1),
        .adc_i   (adc_data),
        .cnt_o   (cnt),
        .data_o  (out_data),
        .valid_o (out_valid)
    );

    decim_clkexp #(.FACT_W(FACT_W)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .halt_i    (halt),
        .cnt_i     (cnt),
        .n_m1_i    (n_m1),
        .mode_i    (mode),
        .div_clk_o (div_clk),
        .clk_out_o (clk_out)
    );

    assign acq_active = run;

endmodule

// File: rtl/decim_sampler_chk.sv
module decim_sampler_chk
    import decim_pkg::*;
#(
    parameter int FACT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acq_start,
    input logic              acq_stop,
    input logic              acq_active,
    input logic              out_valid,
    input logic              div_clk,
    input logic [FACT_W-1:0] n_m1,
    input clk_mode_e         mode
);

    assert_valid_in_acq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> acq_active);

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_start && !acq_stop && !acq_active) |=> acq_active);

    assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_active && acq_stop) |=> (!acq_active && !out_valid && !div_clk));

    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !acq_active |-> !div_clk);

    assert_rise_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_clk) |-> out_valid);

    assert_nlatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_active && $past(acq_active)) |-> $stable(n_m1));

    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_active && $past(acq_active)) |-> $stable(mode));

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_active && acq_stop) |=> !acq_active);

endmodule

bind decim_sampler decim_sampler_chk #(.FACT_W(FACT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acq_start  (acq_start),
    .acq_stop   (acq_stop),
    .acq_active (acq_active),
    .out_valid  (out_valid),
    .div_clk    (div_clk),
    .n_m1       (n_m1),
    .mode       (mode)
);

// File: tb/decim_sampler_tb.sv
module decim_sampler_tb;

    localparam int DATA_W = 14;
    localparam int FACT_W = 16;
    localparam int HALF   = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acq_start = 1'b0;
    logic              acq_stop = 1'b0;
    logic [FACT_W-1:0] div_m1 = '0;
    logic [DATA_W-1:0] adc_data = '0;
    logic [DATA_W-1:0] out_data;
    logic              out_valid;
    logic              acq_active;
    logic              clk_out;

    int n_checks = 0;
    int n_errs   = 0;

    always #HALF clk = ~clk;

    decim_sampler #(.DATA_W(DATA_W), .FACT_W(FACT_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_start  (acq_start),
        .acq_stop   (acq_stop),
        .div_m1     (div_m1),
        .adc_data   (adc_data),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .acq_active (acq_active),
        .clk_out    (clk_out)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_valid(int k, int n);
        return ((k - 1) % n) == 0;
    endfunction

    function automatic bit exp_div(int k, int n);
        int h = (n / 2 < 1) ? 1 : n / 2;
        return ((k - 1) % n) < h;
    endfunction

    task automatic idle_checks(int n, int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk("R3", "idle valid", out_valid, 0);
            chk("R10", "idle active", acq_active, 0);
            if (n > 1) chk("R6", "idle clk_out", clk_out, 0);
            else begin
                chk("R4", "idle copy low", clk_out, 0);
                @(posedge clk); #5;
                chk("R4", "idle copy high", clk_out, 1);
            end
        end
    endtask

    task automatic run_acq(int n, int len, bit poke);
        logic [DATA_W-1:0] last;
        @(negedge clk);
        div_m1    = FACT_W'(n - 1);
        acq_start = 1'b1;
        adc_data  = DATA_W'($urandom);
        @(negedge clk);
        acq_start = 1'b0;
        chk("R2", "active after start", acq_active, 1);
        chk("R3", "no strobe yet", out_valid, 0);
        if (n > 1) chk("R6", "clk_out low before first keep", clk_out, 0);
        adc_data = DATA_W'($urandom);
        last     = adc_data;
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            chk("R1", "strobe spacing", out_valid, exp_valid(k, n));
            if (exp_valid(k, n)) chk("R2", "kept word", out_data, last);
            if (n > 1) chk("R5", "divided clock shape", clk_out, exp_div(k, n));
            else chk("R4", "copy low phase", clk_out, 0);
            chk("R8", "still active", acq_active, 1);
            acq_start = 1'b0;
            if (poke) begin
                // R8 R9: factor changes, including to zero, must not matter.
                div_m1 = (k == 2) ? '0 : FACT_W'($urandom);
                // R10: a second start mid-acquisition is ignored.
                if (k == 3) acq_start = 1'b1;
            end
            adc_data = DATA_W'($urandom);
            last     = adc_data;
            if (n == 1) begin
                @(posedge clk); #5;
                chk("R4", "copy high phase", clk_out, 1);
            end
        end
        @(negedge clk);
        acq_start = 1'b0;
        chk("R1", "strobe spacing at stop", out_valid, exp_valid(len + 1, n));
        acq_stop = 1'b1;
        div_m1   = FACT_W'(n - 1);
        @(negedge clk);
        acq_stop = 1'b0;
        chk("R7", "active drops", acq_active, 0);
        chk("R7", "no strobe after stop", out_valid, 0);
        if (n > 1) chk("R7", "clk_out parked", clk_out, 0);
        idle_checks(n, 4);
    endtask

    initial begin
        #(2 * HALF * 190000);
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        div_m1 = 16'd3;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R6", "reset clk_out", clk_out, 0);
            chk("R3", "reset valid", out_valid, 0);
            chk("R6", "reset active", acq_active, 0);
        end
        rst_n = 1'b1;
        idle_checks(4, 2);

        // R10: stop alone while idle, then start with stop together.
        @(negedge clk); acq_stop = 1'b1;
        @(negedge clk); acq_stop = 1'b0;
        chk("R10", "stop while idle", acq_active, 0);
        acq_start = 1'b1; acq_stop = 1'b1;
        @(negedge clk); acq_start = 1'b0; acq_stop = 1'b0;
        chk("R10", "start+stop while idle", acq_active, 0);
        chk("R10", "no strobe", out_valid, 0);

        run_acq(1, 20, 1'b0);
        run_acq(2, 11, 1'b0);
        run_acq(3, 17, 1'b1);
        run_acq(8, 11, 1'b1);   // R7: stop while clock high mid-period
        run_acq(5, 9, 1'b0);
        run_acq(1, 12, 1'b1);   // R9: copy mode held despite nonzero factor
        for (int r = 0; r < 6; r++) begin
            run_acq(2 + int'($urandom % 30), 5 + int'($urandom % 60), 1'($urandom));
        end
        run_acq(65536, 65540, 1'b0);  // R1 R5: largest factor

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule